// File: doc/BRIEF.md
# Bus Ownership Handshake Unit

This unit sits on the requesting side of a three-wire external bus arbitration scheme. Internal logic signals that it needs the external bus, and the unit raises a bus request toward an external arbiter. When the arbiter's grant is seen together with a pending request, the unit takes ownership on the next clock edge. It raises a bus-driven indication and an output enable that controls the address, data and control pad drivers, and it tells the transfer engine when a new access may begin.

Ownership is sticky. Once the unit owns the bus, it keeps it through idle cycles for as long as the grant stays asserted, so a system with a single master and a grant tied high never stalls on the handshake. When the grant is withdrawn, an idle owner releases the bus at the next edge. An owner with an access in flight keeps driving until that access's last transfer completes, and releases on the edge that samples that completion.

The transfer engine is represented by three strobes: a start pulse, a last-transfer-done pulse and a flag saying whether more internal accesses are queued.

Top module: `bus_hold_arb`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `req_o`, `driven_o` and `oe_o` are 0 after that edge, and `start_ok_o` is 0.
- R2: A 1 on `int_req_i` at a rising edge sets `req_o` to 1 after that edge. This takes priority over any clearing in the same cycle.
- R3: An accepted start (`xfer_start_i` while `start_ok_o` is 1) with `more_pend_i` at 0 and no new `int_req_i` clears `req_o` at that edge. With `more_pend_i` at 1, `req_o` stays 1. `req_o` otherwise holds its value.
- R4: A non-owner becomes owner (`driven_o` = 1 after the edge) only when `grant_i` and `req_o` are both 1 at that edge. A grant with no request leaves it a non-owner.
- R5: `start_ok_o` is 1 exactly when `grant_i` is 1 and the unit owns the bus with no access in flight. A `xfer_start_i` while `start_ok_o` is 0 is ignored: it neither starts an access nor changes `req_o`.
- R6: An owner with no access in flight keeps `driven_o` at 1 for as long as `grant_i` stays 1, even when no access starts.
- R7: When `grant_i` is 0 at an edge and the owner has no access in flight, `driven_o` and `oe_o` are 0 after that edge.
- R8: When `grant_i` is 0 while an access is in flight, `driven_o` stays 1 until the edge that samples `xfer_last_i`. After that edge, the unit keeps ownership only if `grant_i` was 1 at that edge.
- R9: `oe_o` equals `driven_o` in every cycle. Both change only at rising clock edges.
- R10: With `grant_i` held at 1, the unit does not lose ownership after its first takeover, whatever start and done sequence the engine produces.
- R11: `xfer_last_i` while no access is in flight is ignored and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_req_i | input | 1 | Pulse: a new internal access needs the external bus |
| more_pend_i | input | 1 | Another internal access is queued behind the one starting |
| xfer_start_i | input | 1 | Pulse: the transfer engine begins an external access |
| xfer_last_i | input | 1 | Pulse: the last transfer of the current access completes |
| grant_i | input | 1 | Bus grant from the external arbiter, active high |
| req_o | output | 1 | Bus request to the arbiter |
| start_ok_o | output | 1 | The engine may begin an access in this cycle |
| driven_o | output | 1 | The unit is the current master and drives the bus |
| oe_o | output | 1 | Output enable for bus pads (0 = three-state) |

## Verification
The bench goes after the ways a release can be timed wrongly, because each one causes a real bus fault:
- Releasing on grant loss while an access is in flight would cut a transfer short. The bench drops the grant mid-access and holds the completion back for several cycles.
- Releasing an idle owner one cycle late would cause two masters to drive the bus at once. The bench watches the edge right after the grant falls.
- The bench also tries to start an access before ownership has been re-entered, and sends completions while no access is in flight. A design that acted on either would start a transfer without driving the bus, or would drop a pending request.
- A long stretch with the grant tied high shows any design that drops ownership while parked.

// File: rtl/bus_hold_arb.sv
module bus_hold_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic int_req_i,
  input  logic more_pend_i,
  input  logic xfer_start_i,
  input  logic xfer_last_i,
  input  logic grant_i,
  output logic req_o,
  output logic start_ok_o,
  output logic driven_o,
  output logic oe_o
);

  typedef enum logic [1:0] {FREE, RUN, PARK, DRAIN} st_t;

  st_t st, nx;
  logic accept;

  assign start_ok_o = grant_i && (st == PARK);
  assign accept     = start_ok_o && xfer_start_i;

  always_comb begin
    nx = st;
    unique case (st)
      FREE:  if (grant_i && req_o) nx = PARK;
      PARK:  if (!grant_i) nx = FREE;
             else if (xfer_start_i) nx = RUN;
      RUN:   if (xfer_last_i) nx = grant_i ? PARK : FREE;
             else if (!grant_i) nx = DRAIN;
      DRAIN: if (xfer_last_i) nx = grant_i ? PARK : FREE;
             else if (grant_i) nx = RUN;
      default: nx = FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FREE;
      req_o    <= 1'b0;
      driven_o <= 1'b0;
      oe_o     <= 1'b0;
    end else begin
      st       <= nx;
      driven_o <= (nx != FREE);
      oe_o     <= (nx != FREE);
      if (int_req_i)                  req_o <= 1'b1;
      else if (accept && !more_pend_i) req_o <= 1'b0;
    end
  end

endmodule

module bus_hold_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic int_req_i,
  input logic more_pend_i,
  input logic xfer_start_i,
  input logic xfer_last_i,
  input logic grant_i,
  input logic req_o,
  input logic start_ok_o,
  input logic driven_o,
  input logic oe_o
);

  logic flight;

  always_ff @(posedge clk) begin
    if (!rst_n) flight <= 1'b0;
    else        flight <= (flight && !xfer_last_i) || (start_ok_o && xfer_start_i);
  end

  // R3
  req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(start_ok_o && xfer_start_i && !more_pend_i && !int_req_i));

  // R4
  takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(driven_o) |-> $past(grant_i && req_o));

  // R5
  start_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok_o |-> (driven_o && grant_i && !flight));

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_i && !flight) |=> !driven_o);

  // R8
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (driven_o && flight && !xfer_last_i) |=> driven_o);

  // R9
  oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    driven_o == oe_o);

endmodule

bind bus_hold_arb bus_hold_arb_chk i_chk (.*);

// File: tb/test_bus_hold_arb.sv
`timescale 1ns/1ps
module test_bus_hold_arb;

  logic clk = 1'b0, rst_n = 1'b0;
  logic int_req = 1'b0, more = 1'b0, start = 1'b0, last = 1'b0, grant = 1'b0;
  logic req_o, start_ok_o, driven_o, oe_o;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_own = 0, m_flight = 0, m_req = 0;

  always #2.5 clk = ~clk;

  bus_hold_arb i_bus_hold_arb (
    .clk(clk), .rst_n(rst_n), .int_req_i(int_req), .more_pend_i(more),
    .xfer_start_i(start), .xfer_last_i(last), .grant_i(grant),
    .req_o(req_o), .start_ok_o(start_ok_o), .driven_o(driven_o), .oe_o(oe_o));

  always @(posedge clk) begin
    bit acc, n_own, n_flight, n_req;
    acc = m_own && !m_flight && grant && start;
    n_own = m_own; n_flight = m_flight; n_req = m_req;
    if (!rst_n) begin
      n_own = 0; n_flight = 0; n_req = 0;
    end else begin
      if (int_req) n_req = 1;
      else if (acc && !more) n_req = 0;
      if (!m_own) n_own = grant && m_req;
      else if (m_flight) begin
        if (last) begin n_flight = 0; n_own = grant; end
      end else begin
        if (!grant) n_own = 0;
        else if (acc) n_flight = 1;
      end
    end
    m_own = n_own; m_flight = n_flight; m_req = n_req;
  end

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic ir, logic mp, logic st, logic ld, logic g);
    @(negedge clk);
    expect_bit("R2/R3 req_o", req_o, m_req);
    expect_bit("R4/R7/R8 driven_o", driven_o, m_own);
    expect_bit("R9 oe_o", oe_o, m_own);
    int_req = ir; more = mp; start = st; last = ld; grant = g;
    #0.5;
    expect_bit("R5 start_ok_o", start_ok_o, m_own && !m_flight && grant && rst_n);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc(0, 0, 0, 0, 1);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0);
    // R1
    expect_bit("R1 req", req_o, 0);
    expect_bit("R1 driven", driven_o, 0);
    expect_bit("R1 oe", oe_o, 0);
    expect_bit("R1 start_ok", start_ok_o, 0);

    // R4: grant without request
    repeat (3) cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    expect_bit("R4 no takeover", driven_o, 0);

    // R5: start while not owner is ignored
    cyc(0, 0, 1, 0, 1);
    cyc(1, 0, 0, 0, 0);
    expect_bit("R5 ignored start", req_o, 0);
    cyc(0, 0, 0, 0, 0);
    expect_bit("R2 req set", req_o, 1);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1);
    expect_bit("R5 start before ownership", req_o, 1);
    cyc(0, 0, 0, 0, 1);
    expect_bit("R4 takeover", driven_o, 1);

    // R11: done while idle owner
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1);
    expect_bit("R11 driven kept", driven_o, 1);
    expect_bit("R11 start_ok kept", start_ok_o, 1);

    // R3: more pending keeps request
    cyc(0, 1, 1, 0, 1);
    cyc(0, 0, 0, 0, 1);
    expect_bit("R3 held with more", req_o, 1);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 1);
    expect_bit("R3 cleared", req_o, 0);
    cyc(0, 0, 0, 1, 1);

    // R6: parking
    repeat (10) cyc(0, 0, 0, 0, 1);
    expect_bit("R6 parked", driven_o, 1);

    // R7: grant drop while idle
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    expect_bit("R7 release", driven_o, 0);
    expect_bit("R7 oe off", oe_o, 0);

    // R8: grant drop mid-access
    cyc(1, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 0);
    repeat (3) cyc(0, 0, 0, 0, 0);
    expect_bit("R8 hold in flight", driven_o, 1);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    expect_bit("R8 release after last", driven_o, 0);

    // R10: tied grant, many accesses
    cyc(1, 0, 0, 0, 1);
    repeat (3) cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 400; i++) begin
      cyc(logic'($urandom_range(0, 3) == 0), logic'($urandom_range(0, 1)),
          logic'($urandom_range(0, 2) == 0), logic'($urandom_range(0, 3) == 0), 1);
      expect_bit("R10 tied grant", driven_o, 1);
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(logic'($urandom_range(0, 4) == 0), logic'($urandom_range(0, 1)),
          logic'($urandom_range(0, 2) == 0), logic'($urandom_range(0, 4) == 0),
          logic'($urandom_range(0, 5) != 0));
    end
    cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule